// File: doc/BRIEF.md
# I2C Slave Serial Port

This block is the target side of a two-wire serial bus. It watches the clock and data lines through synchronizers and spots bus START and STOP conditions. It compares the first byte of each transfer with a programmable address. It then takes in write data or sends read data, and drives the data line only by pulling it low. Received bytes pass from a shift register into a holding buffer, so the next byte can begin shifting before the host has collected the previous one.

The host sees four byte-wide registers: control (0), status (1), buffer (2) and address (3). It also sees one interrupt output, which mirrors a flag in the control register. The host selects one of five operating modes. Two modes use 7-bit addressing, two use 10-bit addressing, and either width can also raise interrupts on START and STOP. The fifth mode raises interrupts only on START and STOP and never answers the bus.

10-bit addressing is matched in two stages. Software loads the high-byte pattern, sees the match interrupt, and then loads the low address byte before the master sends it.

Top module: `i2c_slave_port`

## Requirements
- R1: Control register: bits [3:0] mode, bit 4 spare, bit 5 enable, bit 6 overflow, bit 7 interrupt flag. Modes are 0x6 (7-bit), 0x7 (10-bit), 0xE (7-bit plus START/STOP interrupts), 0xF (10-bit plus START/STOP interrupts) and 0xB (START/STOP interrupts only, slave idle). With enable clear, or with any other mode code, the port never acknowledges, never raises the interrupt flag and keeps the status register at zero. All registers reset to zero.
- R2: The data-line output enable only ever pulls the line low. It is released after each ACK clock and whenever the slave is not transmitting.
- R3: When a byte that the slave acknowledges completes, it is copied into the buffer. Status bit 0 (buffer full) and the interrupt flag are then set. Reading the buffer (register 2) clears buffer full.
- R4: A byte that completes while the buffer is full or the overflow bit is set is not acknowledged and not stored, and the overflow bit is set. The host clears overflow and the interrupt flag by writing 0 to them.
- R5: In 7-bit modes, an address byte whose bits [7:1] equal address register bits [7:1] is acknowledged. Bit 0 of that byte selects read (1) or write (0). A mismatched byte is not acknowledged, and every later byte up to the next START or STOP is ignored.
- R6: Status bit 3 is set by a START and cleared by a STOP. Status bit 4 is set by a STOP and cleared by a START. The two bits are never both set.
- R7: In modes 0xE, 0xF and 0xB, START and STOP each set the interrupt flag. In modes 0x6 and 0x7 they do not. In mode 0xB no byte is acknowledged.
- R8: In 10-bit modes, a write high byte is acknowledged when it has the form 11110xx0 and its bits [7:1] equal address register bits [7:1]. Status bit 1 (update address) is then set, and the next byte must equal the whole address register. A low-byte match sets bit 1 again. Writing the address register clears bit 1. After a full match, a repeated START with the high byte and bit 0 at 1 starts a read. A STOP cancels the full match.
- R9: Bits are sampled MSB first on SCL rising edges. An acknowledged byte is answered by holding SDA low through the ninth clock.
- R10: On a read, the buffer is sent MSB first, each bit changing while SCL is low. The buffer is sent again after every master ACK, and the slave releases SDA for good after a master NACK.
- R11: Status bit 5 is 1 when the last stored byte was data and 0 when it was an address. Status bit 2 is 1 during a read transfer and is cleared by STOP.
- R12: A START seen in the middle of a transfer (repeated START) abandons it and begins a new address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| reg_addr | input | AW | Host register select |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt flag |

## Verification
The bench targets a byte that arrives while the buffer still holds an unread one. A design that got this wrong would acknowledge it and silently overwrite the held byte instead of refusing it and flagging overflow. It also checks that after a mismatched address the slave stays deaf to later bytes until a repeated START. A design that kept matching would acknowledge stray data. The two-stage 10-bit sequence is exercised with a correct and a wrong low byte, and with a read attempted without a prior full match. A design that compared both stages against one value, or kept the full match across STOP, would acknowledge wrongly. Read transfers finish with a master NACK followed by extra clocks, which exposes a slave that keeps driving data.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    E_IDLE, E_ADDR, E_ACK, E_RXD, E_TXD, E_TXACK
  } eng_st_t;

  localparam int RA_CTRL = 0;
  localparam int RA_STAT = 1;
  localparam int RA_BUF  = 2;
  localparam int RA_ADR  = 3;

  localparam logic [3:0] MODE_S7   = 4'h6;
  localparam logic [3:0] MODE_S10  = 4'h7;
  localparam logic [3:0] MODE_S7I  = 4'hE;
  localparam logic [3:0] MODE_S10I = 4'hF;
  localparam logic [3:0] MODE_IONLY = 4'hB;

  function automatic logic is_slave_mode(input logic [3:0] m);
    return (m == MODE_S7) || (m == MODE_S10) || (m == MODE_S7I) || (m == MODE_S10I);
  endfunction

  function automatic logic has_ss_irq(input logic [3:0] m);
    return (m == MODE_S7I) || (m == MODE_S10I) || (m == MODE_IONLY);
  endfunction
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain  <= '1;
        q_d[g] <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], din[g]};
        q_d[g] <= chain[STAGES-1];
      end
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic scl,
  input  logic sda,
  input  logic scl_d,
  input  logic sda_d,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  always_comb begin
    scl_rise  = scl && !scl_d;
    scl_fall  = !scl && scl_d;
    bus_start = scl && scl_d && sda_d && !sda;
    bus_stop  = scl && scl_d && !sda_d && sda;
  end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_on,
  input  logic          ten_bit,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic [DW-1:0] adr,
  input  logic [DW-1:0] tx_byte,
  input  logic          buf_full,
  input  logic          ovf,
  output logic          sda_oe,
  output logic [DW-1:0] rx_byte,
  output logic          rx_store,
  output logic          rx_is_data,
  output logic          rx_ovf,
  output logic          rd_go,
  output logic          upd_set,
  output logic          tx_done,
  output logic          rw_bit
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  eng_st_t        st, after;
  logic [DW-1:0]  sh;
  logic [CW-1:0]  cnt;
  logic           lo_stage, full10, mack;
  logic           hit, rd, hi_ok, room, ack, byte_end;

  always_comb begin
    room  = !buf_full && !ovf;
    hi_ok = (sh[DW-1:DW-5] == 5'b11110) && (sh[DW-1:1] == adr[DW-1:1]);
    hit   = 1'b0;
    rd    = 1'b0;
    if (st == E_RXD) begin
      hit = 1'b1;
    end else if (st == E_ADDR) begin
      if (!ten_bit) begin
        hit = (sh[DW-1:1] == adr[DW-1:1]);
        rd  = sh[0];
      end else if (!lo_stage) begin
        rd  = sh[0];
        hit = hi_ok && (!sh[0] || full10);
      end else begin
        hit = (sh == adr);
      end
    end
    ack      = hit && (rd || room);
    byte_end = scl_fall && (cnt == LAST) && ((st == E_ADDR) || (st == E_RXD));
  end

  always_ff @(posedge clk) begin
    rx_store <= 1'b0;
    rx_ovf   <= 1'b0;
    rd_go    <= 1'b0;
    upd_set  <= 1'b0;
    tx_done  <= 1'b0;
    if (rst || !slave_on) begin
      st         <= E_IDLE;
      after      <= E_IDLE;
      sda_oe     <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      lo_stage   <= 1'b0;
      full10     <= 1'b0;
      mack       <= 1'b0;
      rw_bit     <= 1'b0;
      rx_is_data <= 1'b0;
    end else if (bus_start) begin
      st       <= E_ADDR;
      cnt      <= '0;
      lo_stage <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (bus_stop) begin
      st     <= E_IDLE;
      sda_oe <= 1'b0;
      full10 <= 1'b0;
      rw_bit <= 1'b0;
    end else begin
      case (st)
        E_ADDR, E_RXD: begin
          if (scl_rise && cnt != LAST) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_end) begin
            rx_is_data <= (st == E_RXD);
            rx_store   <= ack && !rd;
            rx_ovf     <= hit && !rd && !room;
            sda_oe     <= ack;
            st         <= ack ? E_ACK : E_IDLE;
            if (ack && rd) begin
              rd_go  <= 1'b1;
              rw_bit <= 1'b1;
              after  <= E_TXD;
            end else if (st == E_ADDR && ten_bit && !lo_stage) begin
              after    <= E_ADDR;
              lo_stage <= ack;
              upd_set  <= ack;
            end else begin
              after <= E_RXD;
              if (st == E_ADDR) rw_bit <= 1'b0;
              if (st == E_ADDR && ten_bit) begin
                full10  <= ack;
                upd_set <= ack;
              end
            end
          end
        end
        E_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            st  <= after;
            if (after == E_TXD) begin
              sh     <= tx_byte;
              sda_oe <= !tx_byte[DW-1];
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        E_TXD: begin
          if (scl_rise && cnt != LAST) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0;
              st     <= E_TXACK;
            end else begin
              sh     <= {sh[DW-2:0], 1'b0};
              sda_oe <= !sh[DW-2];
            end
          end
        end
        E_TXACK: begin
          if (scl_rise) begin
            mack <= !sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx_done <= 1'b1;
              sh      <= tx_byte;
              sda_oe  <= !tx_byte[DW-1];
              cnt     <= '0;
              st      <= E_TXD;
            end else begin
              st <= E_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rx_byte = sh;

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !slave_on |=> !sda_oe) else $error("slave drove SDA while off"); // R1
  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST) else $error("bit counter out of range"); // R9
  AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    (st == E_TXD) |-> rw_bit) else $error("transmitting outside read"); // R10
endmodule

// File: rtl/i2c_slave_port.sv
module i2c_slave_port
  import i2cs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [1:0] ln_q, ln_q_d;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  logic [3:0]    mode;
  logic          en, spare, irq_f, ovf_f;
  logic [DW-1:0] adr_r, buf_r;
  logic          st_f, sp_f, bf, upd, dna;

  logic          slave_on, bus_on, ss_irq;
  logic [DW-1:0] rx_byte;
  logic          rx_store, rx_is_data, rx_ovf, rd_go, upd_set, tx_done, rw_bit;
  logic          hw_irq, ctrl_we, buf_re;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({scl_i, sda_i}), .q(ln_q), .q_d(ln_q_d)
  );

  i2cs_cond u_cond (
    .scl(ln_q[1]), .sda(ln_q[0]), .scl_d(ln_q_d[1]), .sda_d(ln_q_d[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  always_comb begin
    slave_on = en && is_slave_mode(mode);
    ss_irq   = en && has_ss_irq(mode);
    bus_on   = slave_on || ss_irq;
    hw_irq   = rx_store || rd_go || tx_done || (ss_irq && (bus_start || bus_stop));
    ctrl_we  = reg_wr && (reg_addr == AW'(RA_CTRL));
    buf_re   = reg_rd && (reg_addr == AW'(RA_BUF));
  end

  i2cs_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .slave_on(slave_on), .ten_bit(mode[0]),
    .sda_s(ln_q[0]), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .adr(adr_r), .tx_byte(buf_r), .buf_full(bf), .ovf(ovf_f),
    .sda_oe(sda_oe), .rx_byte(rx_byte), .rx_store(rx_store),
    .rx_is_data(rx_is_data), .rx_ovf(rx_ovf), .rd_go(rd_go),
    .upd_set(upd_set), .tx_done(tx_done), .rw_bit(rw_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0; en <= 1'b0; spare <= 1'b0; irq_f <= 1'b0; ovf_f <= 1'b0;
    end else begin
      if (ctrl_we) begin
        mode  <= reg_wdata[3:0];
        spare <= reg_wdata[4];
        en    <= reg_wdata[5];
      end
      ovf_f <= rx_ovf || (ctrl_we ? reg_wdata[6] : ovf_f);
      irq_f <= hw_irq || (ctrl_we ? reg_wdata[7] : irq_f);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_r <= '0; buf_r <= '0; bf <= 1'b0; upd <= 1'b0; dna <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == AW'(RA_ADR)) adr_r <= reg_wdata;
      if (upd_set) upd <= 1'b1;
      else if (reg_wr && reg_addr == AW'(RA_ADR)) upd <= 1'b0;
      if (rx_store) begin
        buf_r <= rx_byte;
        bf    <= 1'b1;
        dna   <= rx_is_data;
      end else begin
        if (reg_wr && reg_addr == AW'(RA_BUF)) buf_r <= reg_wdata;
        if (buf_re) bf <= 1'b0;
        if (rd_go) dna <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_on) begin
      st_f <= 1'b0;
      sp_f <= 1'b0;
    end else if (bus_start) begin
      st_f <= 1'b1;
      sp_f <= 1'b0;
    end else if (bus_stop) begin
      st_f <= 1'b0;
      sp_f <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (int'(reg_addr))
        RA_CTRL: reg_rdata <= {irq_f, ovf_f, en, spare, mode};
        RA_STAT: reg_rdata <= {2'b00, dna, sp_f, st_f, rw_bit, upd, bf};
        RA_BUF:  reg_rdata <= buf_r;
        default: reg_rdata <= adr_r;
      endcase
    end
  end

  assign irq = irq_f;

  AST_STORE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
    rx_store |-> (!bf && !ovf_f)) else $error("byte stored over unread buffer"); // R4
  AST_IRQ_AFTER_STORE: assert property (@(posedge clk) disable iff (rst)
    rx_store |=> irq_f) else $error("store without interrupt"); // R3
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(st_f && sp_f)) else $error("start and stop status both set"); // R6
endmodule

// File: tb/tb_i2c_slave_port.sv
module tb_i2c_slave_port;
  localparam int CLK_NS = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sda_oe, irq;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  logic mon_on = 1'b0;
  logic [7:0] ctrl_base = 8'h26;

  int req_n = 0, ack_n = 0;
  logic req_w = 1'b0;
  logic [1:0] req_a = '0;
  logic [7:0] req_d = '0, res_d = '0;

  always #(CLK_NS/2) clk = ~clk;

  i2c_slave_port dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Host agent: sole driver of the register bus; also the scoreboard monitor.
  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (req_n != ack_n) begin
        if (req_w) bus_wr(req_a, req_d);
        else bus_rd(req_a, res_d);
        ack_n = req_n;
      end else if (mon_on && irq) begin
        logic [7:0] got;
        bus_rd(2'd2, got);
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3 unexpected byte actual=%h expected=none", got);
        end else begin
          chk("R3 scoreboard byte", got, exp_q.pop_front());
        end
        bus_wr(2'd0, ctrl_base);
      end
    end
  end

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    req_a = a; req_w = 1'b0; req_n++;
    wait (ack_n == req_n);
    d = res_d;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    req_a = a; req_d = d; req_w = 1'b1; req_n++;
    wait (ack_n == req_n);
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic m_bit_w(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic m_bit_r(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic m_write(input logic [7:0] v, output logic ak);
    logic x;
    for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
    m_bit_r(x);
    ak = !x;
  endtask

  task automatic m_read(output logic [7:0] v, input logic ak);
    for (int i = 7; i >= 0; i--) m_bit_r(v[i]);
    m_bit_w(!ak);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic ak;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    reg_read(2'd0, d); chk("R1 reset control", d, 8'h00);
    reg_read(2'd1, d); chk("R1 reset status", d, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    chk("R2 reset sda_oe", {7'd0, sda_oe}, 8'h00);

    // Disabled port ignores the bus
    reg_write(2'd3, 8'hA0);
    reg_write(2'd0, 8'h06);
    m_start(); m_write(8'hA0, ak); m_stop();
    chk("R1 disabled no ack", {7'd0, ak}, 8'h00);
    chk("R1 disabled no irq", {7'd0, irq}, 8'h00);
    reg_read(2'd1, d); chk("R1 disabled status", d, 8'h00);

    // 7-bit write stream through the scoreboard
    reg_write(2'd0, ctrl_base);
    m_start();
    repeat (4) @(negedge clk);
    chk("R7 no start irq in plain mode", {7'd0, irq}, 8'h00);
    mon_on = 1'b1;
    exp_q.push_back(8'hA0); m_write(8'hA0, ak); chk("R5 address ack", {7'd0, ak}, 8'h01);
    exp_q.push_back(8'h3C); m_write(8'h3C, ak); chk("R9 data ack", {7'd0, ak}, 8'h01);
    exp_q.push_back(8'hC5); m_write(8'hC5, ak); chk("R3 double buffer ack", {7'd0, ak}, 8'h01);
    exp_q.push_back(8'h01); m_write(8'h01, ak); chk("R9 data ack lsb", {7'd0, ak}, 8'h01);
    m_stop();
    repeat (40) @(negedge clk);
    mon_on = 1'b0;
    chk("R3 all bytes delivered", 8'(exp_q.size()), 8'h00);
    reg_read(2'd1, d); chk("R6 R11 status after stop", d, 8'h30);
    chk("R2 released after stop", {7'd0, sda_oe}, 8'h00);

    // Mismatched address: ignored until next START
    m_start();
    m_write(8'hB0, ak); chk("R5 mismatch nack", {7'd0, ak}, 8'h00);
    m_write(8'h55, ak); chk("R5 later byte ignored", {7'd0, ak}, 8'h00);
    m_stop();
    chk("R5 no irq after mismatch", {7'd0, irq}, 8'h00);
    reg_read(2'd1, d); chk("R5 buffer not filled", {7'd0, d[0]}, 8'h00);

    // Overflow
    m_start();
    m_write(8'hA0, ak); chk("R4 first byte ack", {7'd0, ak}, 8'h01);
    m_write(8'h11, ak); chk("R4 overflow nack", {7'd0, ak}, 8'h00);
    reg_read(2'd0, d); chk("R4 overflow flag", d, 8'hE6);
    reg_read(2'd2, d); chk("R4 buffer kept", d, 8'hA0);
    m_stop();
    reg_write(2'd0, ctrl_base);
    reg_read(2'd0, d); chk("R4 flags cleared", d, 8'h26);

    // Repeated START and read transfer
    reg_write(2'd2, 8'h96);
    m_start();
    m_write(8'hB0, ak); chk("R12 first address nack", {7'd0, ak}, 8'h00);
    m_start();
    m_write(8'hA1, ak); chk("R12 repeated start match", {7'd0, ak}, 8'h01);
    m_read(d, 1'b1); chk("R10 read byte", d, 8'h96);
    m_read(d, 1'b0); chk("R10 read after ack", d, 8'h96);
    m_read(d, 1'b0); chk("R10 released after nack", d, 8'hFF);
    reg_read(2'd1, d); chk("R11 read flag", {7'd0, d[2]}, 8'h01);
    m_stop();
    reg_read(2'd2, d);
    reg_write(2'd0, ctrl_base);

    // Start/stop interrupts only, slave idle
    reg_write(2'd0, 8'h2B);
    m_start();
    repeat (4) @(negedge clk);
    chk("R7 start irq", {7'd0, irq}, 8'h01);
    reg_read(2'd1, d); chk("R6 start bit", d, 8'h08);
    reg_write(2'd0, 8'h2B);
    m_write(8'hA0, ak); chk("R7 idle slave nack", {7'd0, ak}, 8'h00);
    m_stop();
    repeat (4) @(negedge clk);
    chk("R7 stop irq", {7'd0, irq}, 8'h01);
    reg_read(2'd1, d); chk("R6 stop bit", d, 8'h10);

    // 10-bit two-stage addressing
    reg_write(2'd3, 8'hF2);
    reg_write(2'd0, 8'h27);
    m_start();
    m_write(8'hF2, ak); chk("R8 high byte ack", {7'd0, ak}, 8'h01);
    reg_read(2'd1, d); chk("R8 update flag", d, 8'h0B);
    reg_read(2'd2, d); chk("R8 high byte stored", d, 8'hF2);
    reg_write(2'd3, 8'h34);
    m_write(8'h34, ak); chk("R8 low byte ack", {7'd0, ak}, 8'h01);
    reg_read(2'd2, d); chk("R8 low byte stored", d, 8'h34);
    m_write(8'h77, ak); chk("R8 data ack", {7'd0, ak}, 8'h01);
    reg_read(2'd2, d); chk("R11 data stored", d, 8'h77);
    reg_read(2'd1, d); chk("R11 R8 status data", d, 8'h2A);
    reg_write(2'd3, 8'hF2);
    reg_write(2'd2, 8'hC3);
    m_start();
    m_write(8'hF3, ak); chk("R8 10-bit read ack", {7'd0, ak}, 8'h01);
    m_read(d, 1'b0); chk("R8 10-bit read data", d, 8'hC3);
    m_stop();

    reg_write(2'd0, 8'h27);
    m_start();
    m_write(8'hF2, ak); chk("R8 high byte again", {7'd0, ak}, 8'h01);
    reg_read(2'd2, d);
    reg_write(2'd3, 8'h35);
    m_write(8'h34, ak); chk("R8 wrong low byte nack", {7'd0, ak}, 8'h00);
    m_stop();
    reg_write(2'd3, 8'hF2);
    m_start();
    m_write(8'hF3, ak); chk("R8 read needs full match", {7'd0, ak}, 8'h00);
    m_stop();
    chk("R2 released at end", {7'd0, sda_oe}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule